// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block moves transmit data out of memory under the control of a ring of buffer descriptors. Software builds the ring in a word-addressable memory. Each descriptor takes 8 bytes and holds three things: a 16-bit status halfword, a 16-bit octet count and a 32-bit buffer address. When the engine is enabled, it starts at a configured base address and reads each descriptor in turn. If software has marked a descriptor as ready, the engine reads the buffer one octet at a time and presents the octets on a byte stream that uses a valid/ready handshake. It then writes back the status halfword to close the descriptor.

Each descriptor can carry three control flags. One asks for an event pulse once the buffer has been serviced. One marks the descriptor as the last in the ring. One keeps the descriptor owned by the engine, so that the same buffer is sent again on every pass around the ring. A counter totals the event pulses and raises a global interrupt pulse each time the total reaches a programmable threshold. When a descriptor is not ready, the engine waits and then reads that same descriptor again. A descriptor with a zero octet count is closed as an error.

Top module: `txr_ring_engine`

## Requirements
- R1: While reset is held and right after it, `mem_req`, `out_valid`, `tx_event`, `irq_global` and `err_pulse` are all low.
- R2: A descriptor at byte address A is read as two 32-bit words. The word at A is read first: its bits [31:16] are the status and its bits [15:0] are the octet count. The word at A+4 is read second and is the buffer address. The first descriptor read after `enable` rises is the one at `base_addr`. `mem_addr` and `mem_we` stay stable while a request waits for `mem_ack`.
- R3: For a ready descriptor with octet count N and buffer address P, the octets at byte addresses P to P+N-1 come out in order. Octets are big-endian within a word: the octet at address a sits in bits [31-8*(a mod 4) -: 8]. `out_last` is high only on the Nth octet. `out_data` and `out_last` hold steady while `out_valid` is high and `out_ready` is low.
- R4: Status bit 15 is the Ready flag (1 means the engine owns the descriptor). A descriptor read with Ready at 0 produces no octets. The engine reads that same descriptor again after `idle_delay` idle cycles and does not move on to the next one.
- R5: Closing a descriptor writes only the status halfword: a write to address A with `mem_be` = 4'b1100 and the new status in `mem_wdata[31:16]`. Ready is cleared in the new status and every other status bit keeps its value. The octet count and the buffer address are never written.
- R6: When status bit 9 (continuous) is set on a descriptor with a nonzero count, the status is written back with Ready still at 1. The same buffer is sent again the next time the ring reaches that descriptor.
- R7: When status bit 13 (last in ring) is set, the next descriptor read is at `base_addr`. Otherwise the next descriptor read is at A+8.
- R8: `tx_event` pulses for one cycle, one cycle after the closing write is acknowledged, for each descriptor that is sent with status bit 12 (event request) set. It does not pulse for descriptors with bit 12 clear.
- R9: `irq_global` pulses for one cycle, the cycle after the `tx_event` that brings the event total to `int_threshold`. The total then restarts from zero.
- R10: A ready descriptor with an octet count of zero sends no octets. It is closed with Ready cleared, and `err_pulse` rises for one cycle with no `tx_event`. The engine then moves on to the next descriptor as R7 describes.
- R11: When `enable` is low at the end of a descriptor or at the end of a poll wait, the engine stops issuing memory requests until `enable` rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run the engine |
| base_addr | input | 32 | Byte address of the first descriptor |
| idle_delay | input | 16 | Idle cycles before a non-ready descriptor is read again |
| int_threshold | input | 8 | Event total that triggers the global interrupt |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address of the request |
| mem_be | output | 4 | Byte enables of a write (bit 3 = bits 31:24) |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request done, read data valid |
| mem_rdata | input | 32 | Read data |
| out_data | output | 8 | Transmit octet |
| out_valid | output | 1 | Octet valid |
| out_last | output | 1 | Final octet of the buffer |
| out_ready | input | 1 | Sink accepts the octet |
| tx_event | output | 1 | Serviced-buffer event pulse |
| irq_global | output | 1 | Threshold-reached interrupt pulse |
| err_pulse | output | 1 | Zero-length descriptor error pulse |

## Verification
Octets count as sent on any cycle in which `out_valid` and `out_ready` are both high. The bench records them at the falling edge together with every acknowledged memory access, so the results do not depend on when the memory model answers or when the sink stalls. `tx_event` and `err_pulse` fall due one cycle after the acknowledge of the closing write, and `irq_global` one cycle after that. The bench stamps each pulse with its cycle number and checks that the interrupt's stamp is exactly one greater than the stamp of the event that reached the threshold. Write-back contents, the order of descriptor addresses and the memory image are checked only after the ring has gone quiet, against values worked out from the descriptors the bench placed in memory.

// File: rtl/txr_pkg.sv
package txr_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_GET_STAT, S_GET_PTR, S_GET_BYTE, S_SEND, S_CLOSE, S_WAIT
  } walk_state_e;

  // status halfword bit positions (bit 15 is the most significant)
  localparam int BIT_OWN  = 15;
  localparam int BIT_LAST = 13;
  localparam int BIT_EVT  = 12;
  localparam int BIT_LOOP = 9;

  // big-endian octet pick from a 32-bit memory word
  function automatic logic [7:0] pick_octet(input logic [31:0] word, input logic [1:0] lane);
    case (lane)
      2'd0:    return word[31:24];
      2'd1:    return word[23:16];
      2'd2:    return word[15:8];
      default: return word[7:0];
    endcase
  endfunction

  // status written back when a descriptor is closed
  function automatic logic [15:0] close_status(input logic [15:0] st, input logic bad);
    logic [15:0] r;
    r = st;
    if (bad || !st[BIT_LOOP]) r[BIT_OWN] = 1'b0;
    return r;
  endfunction

endpackage

// File: rtl/txr_poll_timer.sv
module txr_poll_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [TW-1:0] delay,
  output logic          done
);
  logic          active;
  logic [TW-1:0] cnt;

  assign done = active && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (start) begin
      active <= 1'b1;
      cnt    <= delay;
    end else if (active) begin
      if (cnt == '0) active <= 1'b0;
      else           cnt    <= cnt - 1'b1;
    end
  end

  assert_done_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> !done);

endmodule

// File: rtl/txr_irq_count.sv
module txr_irq_count #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          evt,
  input  logic [CW-1:0] threshold,
  output logic          irq
);
  logic [CW-1:0] total;

  function automatic logic reach(input logic [CW-1:0] t, input logic [CW-1:0] thr);
    return ({1'b0, t} + 1'b1) >= {1'b0, thr};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      total <= '0;
      irq   <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (evt) begin
        if (reach(total, threshold)) begin
          total <= '0;
          irq   <= 1'b1;
        end else begin
          total <= total + 1'b1;
        end
      end
    end
  end

  assert_irq_after_evt_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(evt));

endmodule

// File: rtl/txr_walker.sv
module txr_walker
  import txr_pkg::*;
#(
  parameter int AW = 32,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic [AW-1:0] base_addr,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [3:0]    mem_be,
  output logic [31:0]   mem_wdata,
  input  logic          mem_ack,
  input  logic [31:0]   mem_rdata,
  output logic [7:0]    out_data,
  output logic          out_valid,
  output logic          out_last,
  input  logic          out_ready,
  output logic          poll_start,
  input  logic          poll_done,
  output logic          tx_event,
  output logic          err_pulse
);
  localparam logic [AW-1:0] DESC_BYTES = AW'(8);
  localparam logic [AW-1:0] PTR_OFS    = AW'(4);

  walk_state_e   state;
  logic [AW-1:0] cur, ptr;
  logic [15:0]   stat;
  logic [LW-1:0] len, idx;
  logic [7:0]    octet;
  logic          bad;
  logic [AW-1:0] byte_addr;
  logic          fetched_own;

  function automatic logic [AW-1:0] next_desc(input logic [AW-1:0] c, input logic [AW-1:0] b,
                                              input logic last);
    return last ? b : c + DESC_BYTES;
  endfunction

  assign byte_addr   = ptr + AW'(idx);
  assign fetched_own = mem_rdata[16 + BIT_OWN];

  assign mem_req   = (state == S_GET_STAT) || (state == S_GET_PTR) ||
                     (state == S_GET_BYTE) || (state == S_CLOSE);
  assign mem_we    = (state == S_CLOSE);
  assign mem_be    = mem_we ? 4'b1100 : 4'b1111;
  assign mem_wdata = {close_status(stat, bad), 16'h0000};
  assign out_valid = (state == S_SEND);
  assign out_data  = octet;
  assign out_last  = (idx == len - 1'b1);
  assign poll_start = (state == S_GET_STAT) && mem_ack && !fetched_own;

  always_comb begin
    case (state)
      S_GET_PTR:  mem_addr = cur + PTR_OFS;
      S_GET_BYTE: mem_addr = byte_addr;
      default:    mem_addr = cur;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cur       <= '0;
      ptr       <= '0;
      stat      <= '0;
      len       <= '0;
      idx       <= '0;
      octet     <= '0;
      bad       <= 1'b0;
      tx_event  <= 1'b0;
      err_pulse <= 1'b0;
    end else begin
      tx_event  <= 1'b0;
      err_pulse <= 1'b0;
      case (state)
        S_IDLE: if (enable) begin
          cur   <= base_addr;
          state <= S_GET_STAT;
        end
        S_GET_STAT: if (mem_ack) begin
          stat <= mem_rdata[31:16];
          len  <= mem_rdata[LW-1:0];
          bad  <= 1'b0;
          if (!fetched_own)                state <= S_WAIT;
          else if (mem_rdata[LW-1:0] == '0) begin
            bad   <= 1'b1;
            state <= S_CLOSE;
          end else                         state <= S_GET_PTR;
        end
        S_GET_PTR: if (mem_ack) begin
          ptr   <= mem_rdata;
          idx   <= '0;
          state <= S_GET_BYTE;
        end
        S_GET_BYTE: if (mem_ack) begin
          octet <= pick_octet(mem_rdata, byte_addr[1:0]);
          state <= S_SEND;
        end
        S_SEND: if (out_ready) begin
          if (out_last) state <= S_CLOSE;
          else begin
            idx   <= idx + 1'b1;
            state <= S_GET_BYTE;
          end
        end
        S_CLOSE: if (mem_ack) begin
          tx_event  <= stat[BIT_EVT] && !bad;
          err_pulse <= bad;
          cur       <= next_desc(cur, base_addr, stat[BIT_LAST]);
          state     <= enable ? S_GET_STAT : S_IDLE;
        end
        S_WAIT: if (poll_done) state <= enable ? S_GET_STAT : S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_hold_octet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

  assert_hold_request_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  assert_error_no_event_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> !tx_event);

  assert_wait_no_stream_R4: assert property (@(posedge clk) disable iff (!rst_n)
    poll_start |=> !out_valid && !mem_req);

endmodule

// File: rtl/txr_ring_engine.sv
module txr_ring_engine #(
  parameter int AW = 32,
  parameter int LW = 16,
  parameter int TW = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic [AW-1:0] base_addr,
  input  logic [TW-1:0] idle_delay,
  input  logic [CW-1:0] int_threshold,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [3:0]    mem_be,
  output logic [31:0]   mem_wdata,
  input  logic          mem_ack,
  input  logic [31:0]   mem_rdata,
  output logic [7:0]    out_data,
  output logic          out_valid,
  output logic          out_last,
  input  logic          out_ready,
  output logic          tx_event,
  output logic          irq_global,
  output logic          err_pulse
);
  logic poll_start, poll_done;

  txr_walker #(.AW(AW), .LW(LW)) u_walk (
    .clk(clk), .rst_n(rst_n), .enable(enable), .base_addr(base_addr),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .out_data(out_data), .out_valid(out_valid), .out_last(out_last), .out_ready(out_ready),
    .poll_start(poll_start), .poll_done(poll_done),
    .tx_event(tx_event), .err_pulse(err_pulse)
  );

  txr_poll_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(poll_start), .delay(idle_delay), .done(poll_done)
  );

  txr_irq_count #(.CW(CW)) u_irq (
    .clk(clk), .rst_n(rst_n), .evt(tx_event), .threshold(int_threshold), .irq(irq_global)
  );

  assert_quiet_in_reset_R1: assert property (@(posedge clk)
    !rst_n |=> !out_valid && !tx_event && !irq_global && !err_pulse);

endmodule

// File: tb/tb_txr_ring_engine.sv
module tb_txr_ring_engine;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic [31:0] base_addr = '0;
  logic [15:0] idle_delay = 16'd4;
  logic [7:0]  int_threshold = 8'd8;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0]  mem_be;
  logic [7:0]  out_data;
  logic        out_valid, out_last, out_ready;
  logic        tx_event, irq_global, err_pulse;

  txr_ring_engine dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .base_addr(base_addr),
    .idle_delay(idle_delay), .int_threshold(int_threshold),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .out_data(out_data), .out_valid(out_valid), .out_last(out_last), .out_ready(out_ready),
    .tx_event(tx_event), .irq_global(irq_global), .err_pulse(err_pulse)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int vectors = 0, miscompares = 0, cyc = 0;
  logic stall = 1'b0;

  // memory model: 256 words, answers one cycle after a request
  logic [31:0] mem [256];
  initial begin mem_ack = 1'b0; mem_rdata = '0; end
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      if (mem_we) begin
        for (int b = 0; b < 4; b++)
          if (mem_be[b]) mem[mem_addr[9:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
      end else mem_rdata <= mem[mem_addr[9:2]];
    end else mem_ack <= 1'b0;
  end

  always @(posedge clk) begin
    #1;
    out_ready = !stall || (cyc % 3 != 0);
  end
  initial out_ready = 1'b1;

  // observation logs, sampled at the falling edge
  logic [7:0]  byte_log [64];
  logic        last_log [64];
  logic [31:0] rd_log [64];
  logic [31:0] wa_log [16];
  logic [31:0] wd_log [16];
  int          ev_cyc [16];
  int          irq_cyc [16];
  int nb, nr, nw, ne, ni, nerr;

  task automatic clear_logs();
    nb = 0; nr = 0; nw = 0; ne = 0; ni = 0; nerr = 0;
  endtask

  always @(negedge clk) if (rst_n) begin
    if (out_valid && out_ready && nb < 64) begin
      byte_log[nb] = out_data; last_log[nb] = out_last; nb++;
    end
    if (mem_req && mem_ack && !mem_we && mem_addr < 32'h200 && mem_addr[2:0] == 3'd0 && nr < 64) begin
      rd_log[nr] = mem_addr; nr++;
    end
    if (mem_req && mem_ack && mem_we && nw < 16) begin
      wa_log[nw] = mem_addr; wd_log[nw] = mem_wdata; nw++;
    end
    if (tx_event && ne < 16) begin ev_cyc[ne] = cyc; ne++; end
    if (irq_global && ni < 16) begin irq_cyc[ni] = cyc; ni++; end
    if (err_pulse) nerr++;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(input logic [31:0] a);
    logic [31:0] w;
    w = mem[a[9:2]];
    return 8'((w >> (8 * (3 - int'(a[1:0])))) & 32'hFF);
  endfunction

  task automatic put_desc(input logic [31:0] a, input logic [15:0] st, input logic [15:0] len,
                          input logic [31:0] p);
    mem[a[9:2]]     = {st, len};
    mem[a[9:2] + 1] = p;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; enable = 1'b0; stall = 1'b0;
    for (int i = 0; i < 256; i++) mem[i] = 32'hA5000000 ^ (i * 32'h01030507);
    repeat (3) @(posedge clk);
    @(negedge clk);
    clear_logs();
    rst_n = 1'b1;
  endtask

  task automatic wait_writes(input int n, input string req);
    int k = 0;
    while (nw < n && k < 5000) begin @(negedge clk); k++; end
    check(nw >= n, req, nw, n);
  endtask

  task automatic t_reset();
    do_reset();
    @(negedge clk);
    check(!mem_req && !out_valid && !tx_event && !irq_global && !err_pulse, "R1",
          {mem_req, out_valid, tx_event, irq_global, err_pulse}, 0);
  endtask

  task automatic t_basic_ring();
    int n0;
    do_reset();
    base_addr = 32'h100; idle_delay = 16'd4; int_threshold = 8'd8; stall = 1'b1;
    put_desc(32'h100, 16'h9000 | 16'h4000, 16'd5, 32'h201); // own, event, reserved bit 14
    put_desc(32'h108, 16'hA000, 16'd3, 32'h300);            // own, last in ring
    enable = 1'b1;
    wait_writes(2, "R3");
    repeat (60) @(negedge clk);
    check(nb == 8, "R3", nb, 8);
    for (int i = 0; i < 5; i++)
      check(byte_log[i] == exp_byte(32'h201 + i) && last_log[i] == (i == 4), "R3",
            {byte_log[i], 7'd0, last_log[i]}, {exp_byte(32'h201 + i), 7'd0, i == 4});
    for (int i = 0; i < 3; i++)
      check(byte_log[5 + i] == exp_byte(32'h300 + i) && last_log[5 + i] == (i == 2), "R3",
            {byte_log[5 + i], 7'd0, last_log[5 + i]}, {exp_byte(32'h300 + i), 7'd0, i == 2});
    check(rd_log[0] == 32'h100, "R2", rd_log[0], 32'h100);
    check(rd_log[1] == 32'h108, "R7", rd_log[1], 32'h108);
    check(rd_log[2] == 32'h100, "R7", rd_log[2], 32'h100);
    check(nr >= 4, "R4", nr, 4);
    for (int i = 2; i < nr; i++) check(rd_log[i] == 32'h100, "R4", rd_log[i], 32'h100);
    check(wa_log[0] == 32'h100 && wd_log[0][31:16] == 16'h5000, "R5", wd_log[0], 32'h5000_0000);
    check(wa_log[1] == 32'h108 && wd_log[1][31:16] == 16'h2000, "R5", wd_log[1], 32'h2000_0000);
    check(mem[32'h100 >> 2] == {16'h5000, 16'd5} && mem[32'h104 >> 2] == 32'h201, "R5",
          mem[32'h100 >> 2], {16'h5000, 16'd5});
    check(ne == 1, "R8", ne, 1);
    enable = 1'b0;
    repeat (30) @(negedge clk);
    n0 = nr;
    repeat (40) @(negedge clk);
    check(nr == n0 && !mem_req, "R11", nr, n0);
  endtask

  task automatic t_continuous();
    do_reset();
    base_addr = 32'h180; int_threshold = 8'd2;
    put_desc(32'h180, 16'hB200, 16'd2, 32'h222); // own, last, event, continuous
    enable = 1'b1;
    wait_writes(3, "R6");
    enable = 1'b0;
    repeat (40) @(negedge clk);
    for (int i = 0; i < 6; i++)
      check(byte_log[i] == exp_byte(32'h222 + (i % 2)), "R6", byte_log[i], exp_byte(32'h222 + (i % 2)));
    check(wd_log[2][31:16] == 16'hB200, "R6", wd_log[2], 32'hB200_0000);
    check(ne == nw, "R8", ne, nw);
    check(ni >= 1 && irq_cyc[0] == ev_cyc[1] + 1, "R9", irq_cyc[0], ev_cyc[1] + 1);
    check(ni == ne / 2, "R9", ni, ne / 2);
  endtask

  task automatic t_zero_length();
    do_reset();
    base_addr = 32'h1C0; int_threshold = 8'd1; idle_delay = 16'd2;
    put_desc(32'h1C0, 16'h9000, 16'd0, 32'h240); // own, event, zero length
    put_desc(32'h1C8, 16'hA000, 16'd1, 32'h245); // own, last
    enable = 1'b1;
    wait_writes(2, "R10");
    repeat (20) @(negedge clk);
    enable = 1'b0;
    repeat (30) @(negedge clk);
    check(nerr == 1, "R10", nerr, 1);
    check(wd_log[0][31:16] == 16'h1000, "R10", wd_log[0], 32'h1000_0000);
    check(rd_log[1] == 32'h1C8, "R10", rd_log[1], 32'h1C8);
    check(nb == 1 && byte_log[0] == exp_byte(32'h245) && last_log[0], "R10",
          {nb[23:0], byte_log[0]}, {24'd1, exp_byte(32'h245)});
    check(ne == 0 && ni == 0, "R8", ne, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    t_reset();
    t_basic_ring();
    t_continuous();
    t_zero_length();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule